// File: doc/BRIEF.md
# NAND Bus Cycle Timing Generator

This block turns single bus-cycle requests into the strobe waveforms a NAND flash device expects. A request names one of four cycle kinds (command, address, data write, data read) and carries an 8-bit value. The block then drives the command-latch and address-latch enables, the active-low chip enable, the active-low write and read strobes and the data bus. On a read it captures the byte the device returns.

Each phase of a cycle lasts a number of controller clocks set by a packed timing word. The phases are chip-enable setup, strobe low and strobe high, and the low and high lengths are set separately for reads and writes. A turnaround gap is added whenever the transfer direction flips.

After a command cycle the device may go busy, so the block ignores the ready/busy pin for a programmable number of clocks. After that it follows the synchronised pin. The `ready` output is high only when the cycle engine is idle and the device reports ready. A caller issues one request when `req_ready` is high. It then waits on `ready` before the next step that needs the device, such as reading data after a reset command (0xFF).

Top module: `nand_cycle_timer`

## Requirements
- R1: `req_kind` encodes 0 = command, 1 = address, 2 = data write, 3 = data read. From the start of the setup phase to the end of the high phase, `cle` is high only for a command and `ale` only for an address. `dq_oe` is high and `dq_out` equals the request byte for every kind except read.
- R2: A non-read cycle runs in three phases. First `ce_n` is low with both strobes high for `timing_cfg[1:0]`+1 clocks. Then `we_n` is low for `timing_cfg[13:10]`+1 clocks. Then `we_n` is high for `timing_cfg[17:14]`+1 clocks with `ce_n` still low. After that `ce_n` returns high and `req_ready` rises.
- R3: A read cycle has the same setup phase. Then `re_n` is low for `timing_cfg[21:18]`+1 clocks and high for `timing_cfg[25:22]`+1 clocks, and `we_n` stays high throughout.
- R4: Read data is taken from `dq_in` on the last clock of the read-low phase. It appears on `rd_data` with a one-clock `rd_valid` pulse during the first read-high clock. `rd_valid` never pulses for other kinds.
- R5: A timing field of zero still gives a phase of exactly one clock.
- R6: A cycle whose direction (read versus non-read) differs from the previous accepted cycle is preceded by `timing_cfg[9:7]`+1 clocks with `ce_n` high and strobes idle. There is no gap for the same direction, or for the first cycle after reset.
- R7: The end of a command cycle, including the 0xFF reset command, opens a busy window of `timing_cfg[6:2]`+1 clocks. During the window `ready` is low whatever `rb_n` does. Address, write and read cycles open no window.
- R8: `ready` is high only when `req_ready` is high and, outside any busy window, `rb_n` has been high for two clocks through a two-stage synchroniser.
- R9: While reset is held and right after it, `ce_n`, `we_n` and `re_n` are high, `cle`, `ale`, `dq_oe` and `rd_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_kind | input | 2 | Cycle kind (0 cmd, 1 addr, 2 write, 3 read) |
| req_data | input | 8 | Byte to drive for command, address and write |
| req_ready | output | 1 | Cycle engine idle, request accepted this clock |
| timing_cfg | input | 26 | Packed phase lengths (see R2, R3, R6, R7) |
| rb_n | input | 1 | Device ready/busy pin, high = ready |
| dq_in | input | 8 | Data bus value from the device |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| ce_n | output | 1 | Chip enable, active low |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | 8 | Data bus value to the device |
| dq_oe | output | 1 | Data bus output enable |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | One-clock pulse marking a new `rd_data` |
| ready | output | 1 | Controller idle and device ready |

## Verification
A request is accepted on the edge where `req_valid` meets `req_ready`. The first phase clock (gap or setup) is the clock right after that edge. The `rd_valid` pulse lands in the first read-high clock. The busy window starts on the first idle clock after a command. A change on `rb_n` shows on `ready` two clocks later. The bench samples every clock at the falling edge and counts, per cycle, the clocks spent in gap, setup, strobe-low and strobe-high. It compares those counts with lengths computed from the timing word, so any phase that is a clock off is caught. Busy-window lengths are counted from the first idle clock, and synchroniser latency is checked one clock either side of the expected rise.

// File: rtl/nbt_pkg.sv
// Shared types and field widths for the NAND bus cycle timing generator.
// Assumes the timing word is packed exactly as timing_t lays it out.
package nbt_pkg;
    localparam int CE_W   = 2;   // chip-enable setup field width
    localparam int BUSY_W = 5;   // busy window field width
    localparam int GAP_W  = 3;   // turnaround gap field width
    localparam int STRB_W = 4;   // strobe low/high field width
    localparam int PH_W   = STRB_W; // phase counter width (widest FSM field)

    typedef enum logic [1:0] {
        KIND_CMD  = 2'd0,
        KIND_ADDR = 2'd1,
        KIND_WR   = 2'd2,
        KIND_RD   = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GAP   = 3'd1,
        ST_SETUP = 3'd2,
        ST_LOW   = 3'd3,
        ST_HIGH  = 3'd4
    } state_e;

    // MSB first: read high, read low, write high, write low, gap, busy, setup
    typedef struct packed {
        logic [STRB_W-1:0] rd_hi;
        logic [STRB_W-1:0] rd_lo;
        logic [STRB_W-1:0] wr_hi;
        logic [STRB_W-1:0] wr_lo;
        logic [GAP_W-1:0]  gap;
        logic [BUSY_W-1:0] busy;
        logic [CE_W-1:0]   setup;
    } timing_t;

    localparam int CFG_W = $bits(timing_t);
endpackage

// File: rtl/nbt_phase_counter.sv
// Down-counter that times one phase. A load of N makes done rise
// after N further clocks, so the phase that loaded it lasts N+1 clocks.
// Assumes load is only issued on the clock a phase starts.
module nbt_phase_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;

    // Count register: load a new length or step toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - ONE;
    end

    assign done = (cnt == '0);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - ONE)); // R5
endmodule

// File: rtl/nbt_busy_tracker.sv
// Tracks device readiness: synchronises the ready/busy pin and masks it
// for a programmable window after each command cycle.
// Assumes rb_n is asynchronous to clk and arm is a one-clock pulse.
module nbt_busy_tracker #(
    parameter int CNT_W  = 5,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [CNT_W-1:0] dly,
    input  logic             rb_n,
    output logic             nand_ready
);
    logic [SYNC_N-1:0] sync_q;
    logic              win_active;
    logic              win_done;

    // Synchroniser chain for the ready/busy pin.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '0;
        else
            sync_q <= {sync_q[SYNC_N-2:0], rb_n};
    end

    nbt_phase_counter #(.W(CNT_W)) u_win_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (arm),
        .load_val (dly),
        .done     (win_done)
    );

    // Window flag: open on arm, close once the counter has run out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_active <= 1'b0;
        else if (arm)
            win_active <= 1'b1;
        else if (win_done)
            win_active <= 1'b0;
    end

    assign nand_ready = !win_active && sync_q[SYNC_N-1];

    AST_ARM_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !nand_ready); // R7
endmodule

// File: rtl/nand_cycle_timer.sv
// NAND bus cycle timing generator. Accepts one cycle request at a time and
// sequences gap, setup, strobe-low and strobe-high phases whose lengths come
// from the packed timing word. Assumes timing_cfg is stable while a cycle runs.
module nand_cycle_timer
    import nbt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    input  logic [CFG_W-1:0]  timing_cfg,
    input  logic              rb_n,
    input  logic [DATA_W-1:0] dq_in,
    output logic              cle,
    output logic              ale,
    output logic              ce_n,
    output logic              we_n,
    output logic              re_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              ready
);
    timing_t           cfg;
    state_e            state, state_nx;
    kind_e             kind_q;
    logic [DATA_W-1:0] data_q;
    logic              last_rd, have_prev;
    logic              ph_load, ph_done;
    logic [PH_W-1:0]   ph_val;
    logic              accept, req_is_rd, cur_is_rd, in_cycle;
    logic              busy_arm, nand_ready;

    assign cfg       = timing_t'(timing_cfg);
    assign accept    = (state == ST_IDLE) && req_valid;
    assign req_is_rd = (kind_e'(req_kind) == KIND_RD);
    assign cur_is_rd = (kind_q == KIND_RD);

    // Next-state and phase-length selection.
    always_comb begin
        state_nx = state;
        ph_load  = 1'b0;
        ph_val   = '0;
        unique case (state)
            ST_IDLE: if (req_valid) begin
                ph_load = 1'b1;
                if (have_prev && (req_is_rd != last_rd)) begin
                    state_nx = ST_GAP;
                    ph_val   = PH_W'(cfg.gap);
                end else begin
                    state_nx = ST_SETUP;
                    ph_val   = PH_W'(cfg.setup);
                end
            end
            ST_GAP: if (ph_done) begin
                state_nx = ST_SETUP;
                ph_load  = 1'b1;
                ph_val   = PH_W'(cfg.setup);
            end
            ST_SETUP: if (ph_done) begin
                state_nx = ST_LOW;
                ph_load  = 1'b1;
                ph_val   = cur_is_rd ? cfg.rd_lo : cfg.wr_lo;
            end
            ST_LOW: if (ph_done) begin
                state_nx = ST_HIGH;
                ph_load  = 1'b1;
                ph_val   = cur_is_rd ? cfg.rd_hi : cfg.wr_hi;
            end
            ST_HIGH: if (ph_done) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    nbt_phase_counter #(.W(PH_W)) u_phase_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .done     (ph_done)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Request latch and direction history for the turnaround rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= KIND_CMD;
            data_q    <= '0;
            last_rd   <= 1'b0;
            have_prev <= 1'b0;
        end else if (accept) begin
            kind_q    <= kind_e'(req_kind);
            data_q    <= req_data;
            last_rd   <= req_is_rd;
            have_prev <= 1'b1;
        end
    end

    // Read capture on the last clock of the read-low phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= (state == ST_LOW) && ph_done && cur_is_rd;
            if ((state == ST_LOW) && ph_done && cur_is_rd)
                rd_data <= dq_in;
        end
    end

    assign busy_arm = (state == ST_HIGH) && ph_done && (kind_q == KIND_CMD);

    nbt_busy_tracker #(.CNT_W(BUSY_W), .SYNC_N(2)) u_busy (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (busy_arm),
        .dly        (cfg.busy),
        .rb_n       (rb_n),
        .nand_ready (nand_ready)
    );

    assign in_cycle  = (state == ST_SETUP) || (state == ST_LOW) || (state == ST_HIGH);
    assign ce_n      = !in_cycle;
    assign cle       = in_cycle && (kind_q == KIND_CMD);
    assign ale       = in_cycle && (kind_q == KIND_ADDR);
    assign we_n      = !((state == ST_LOW) && !cur_is_rd);
    assign re_n      = !((state == ST_LOW) && cur_is_rd);
    assign dq_oe     = in_cycle && !cur_is_rd;
    assign dq_out    = data_q;
    assign req_ready = (state == ST_IDLE);
    assign ready     = req_ready && nand_ready;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n)); // R3
    AST_STROBE_IN_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !ce_n); // R2
    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale)); // R1
    AST_WE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> dq_oe); // R1
    AST_RDV_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (re_n && $past(!re_n))); // R4
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ce_n && we_n && re_n)); // R8
endmodule

// File: tb/nand_cycle_timer_test.sv
module nand_cycle_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [7:0]  req_data = 8'h00;
    logic        req_ready;
    logic [25:0] timing_cfg = '0;
    logic        rb_n = 1'b1;
    logic [7:0]  dq_in = 8'h00;
    logic        cle, ale, ce_n, we_n, re_n, dq_oe, rd_valid, ready;
    logic [7:0]  dq_out, rd_data;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    // bench-side history for the turnaround rule
    bit have_prev = 0;
    bit last_rd   = 0;
    // results of the most recent run_cycle
    int r_gap, r_setup, r_low, r_high;

    always #5 clk = ~clk;

    nand_cycle_timer uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_data(req_data), .req_ready(req_ready), .timing_cfg(timing_cfg),
        .rb_n(rb_n), .dq_in(dq_in), .cle(cle), .ale(ale), .ce_n(ce_n),
        .we_n(we_n), .re_n(re_n), .dq_out(dq_out), .dq_oe(dq_oe),
        .rd_data(rd_data), .rd_valid(rd_valid), .ready(ready)
    );

    typedef struct packed {
        logic [1:0] kind;
        logic [7:0] data;
        logic [7:0] rdv;
        logic [1:0] ce;
        logic [4:0] busy;
        logic [2:0] gap;
        logic [3:0] wlo;
        logic [3:0] whi;
        logic [3:0] rlo;
        logic [3:0] rhi;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{2'd0, 8'hFF, 8'h00, 2'd1, 5'd3, 3'd2, 4'd2,  4'd1,  4'd3,  4'd2},
        '{2'd1, 8'h12, 8'h00, 2'd0, 5'd0, 3'd2, 4'd0,  4'd0,  4'd1,  4'd1},
        '{2'd2, 8'hA5, 8'h00, 2'd2, 5'd1, 3'd2, 4'd5,  4'd3,  4'd2,  4'd2},
        '{2'd3, 8'h00, 8'h3C, 2'd1, 5'd1, 3'd5, 4'd1,  4'd1,  4'd4,  4'd2},
        '{2'd3, 8'h00, 8'hC3, 2'd0, 5'd1, 3'd5, 4'd1,  4'd1,  4'd6,  4'd0},
        '{2'd2, 8'h5A, 8'h00, 2'd3, 5'd1, 3'd7, 4'd4,  4'd9,  4'd1,  4'd1},
        '{2'd0, 8'h70, 8'h00, 2'd3, 5'd2, 3'd1, 4'd15, 4'd15, 4'd1,  4'd1},
        '{2'd3, 8'h00, 8'h81, 2'd2, 5'd2, 3'd0, 4'd1,  4'd1,  4'd15, 4'd15}
    };

    function automatic logic [25:0] pack_cfg(vec_t v);
        return {v.rhi, v.rlo, v.whi, v.wlo, v.gap, v.busy, v.ce};
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Issue one request and measure every phase of the resulting cycle.
    task automatic run_cycle(input logic [1:0] kind, input logic [7:0] data,
                             input logic [7:0] rdv, input logic [25:0] t);
        bit is_rd;
        int gap_e, ce_e, low_e, high_e;
        int sig_bad, rdv_cnt, rdy_bad, guard;
        logic [7:0] got;
        is_rd = (kind == 2'd3);
        timing_cfg = t;
        dq_in = rdv;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
        r_gap = 0; r_setup = 0; r_low = 0; r_high = 0;
        sig_bad = 0; rdv_cnt = 0; rdy_bad = 0; guard = 0; got = 8'h00;
        while (!req_ready && guard < 200) begin
            if (ready) rdy_bad++;
            if (rd_valid) begin rdv_cnt++; got = rd_data; end
            if (ce_n) begin
                r_gap++;
                if (!we_n || !re_n || cle || ale) sig_bad++;
            end else begin
                if (cle != (kind == 2'd0)) sig_bad++;
                if (ale != (kind == 2'd1)) sig_bad++;
                if (dq_oe != !is_rd) sig_bad++;
                if (!is_rd && dq_out != data) sig_bad++;
                if (is_rd && !we_n) sig_bad++;
                if (!is_rd && !re_n) sig_bad++;
                if (!we_n || !re_n) r_low++;
                else if (r_low == 0) r_setup++;
                else r_high++;
            end
            guard++;
            @(negedge clk);
        end
        gap_e  = (have_prev && (is_rd != last_rd)) ? int'(t[9:7]) + 1 : 0;
        ce_e   = int'(t[1:0]) + 1;
        low_e  = is_rd ? int'(t[21:18]) + 1 : int'(t[13:10]) + 1;
        high_e = is_rd ? int'(t[25:22]) + 1 : int'(t[17:14]) + 1;
        chk("R6", "turnaround clocks", r_gap, gap_e);
        chk("R2", "setup clocks", r_setup, ce_e);
        if (is_rd) begin
            chk("R3", "read low clocks", r_low, low_e);
            chk("R3", "read high clocks", r_high, high_e);
            chk("R4", "rd_valid pulses", rdv_cnt, 1);
            chk("R4", "read byte", int'(got), int'(rdv));
        end else begin
            chk("R2", "write low clocks", r_low, low_e);
            chk("R2", "write high clocks", r_high, high_e);
            chk("R4", "rd_valid pulses on non-read", rdv_cnt, 0);
        end
        chk("R1", "latch/bus signal mismatches", sig_bad, 0);
        chk("R8", "ready while engine busy", rdy_bad, 0);
        have_prev = 1'b1;
        last_rd = is_rd;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R9: values while reset is held
        chk("R9", "ce_n in reset", int'(ce_n), 1);
        chk("R9", "req_ready in reset", int'(req_ready), 1);
        rst_n = 1'b1;
        have_prev = 1'b0;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        do_reset();
        // R9: idle outputs after reset
        chk("R9", "we_n idle", int'(we_n), 1);
        chk("R9", "re_n idle", int'(re_n), 1);
        chk("R9", "cle/ale idle", int'(cle | ale), 0);
        chk("R9", "dq_oe idle", int'(dq_oe), 0);
        chk("R9", "rd_valid idle", int'(rd_valid), 0);
        repeat (3) @(negedge clk);
        chk("R8", "ready with device ready and engine idle", int'(ready), 1);

        // Table of cycles, each measured phase by phase.
        foreach (VEC[i]) begin
            run_cycle(VEC[i].kind, VEC[i].data, VEC[i].rdv, pack_cfg(VEC[i]));
        end

        // R7: 0xFF command opens a busy window of busy+1 clocks.
        repeat (40) @(negedge clk);
        run_cycle(2'd0, 8'hFF, 8'h00, {4'd1, 4'd1, 4'd1, 4'd1, 3'd0, 5'd6, 2'd0});
        n = 0;
        while (!ready && n < 100) begin n++; @(negedge clk); end
        chk("R7", "busy window clocks after 0xFF", n, 7);

        // R7: a write cycle opens no window.
        run_cycle(2'd2, 8'h33, 8'h00, {4'd1, 4'd1, 4'd1, 4'd1, 3'd0, 5'd20, 2'd0});
        chk("R7", "ready right after write", int'(ready), 1);

        // R8: after the window, ready follows rb_n through two stages.
        run_cycle(2'd0, 8'h60, 8'h00, {4'd1, 4'd1, 4'd1, 4'd1, 3'd0, 5'd2, 2'd0});
        rb_n = 1'b0;
        repeat (10) @(negedge clk);
        chk("R8", "ready while device busy", int'(ready), 0);
        rb_n = 1'b1;
        @(negedge clk);
        chk("R8", "ready one clock after rb_n rise", int'(ready), 0);
        @(negedge clk);
        chk("R8", "ready two clocks after rb_n rise", int'(ready), 1);

        // R5: an all-zero timing word gives one-clock phases.
        run_cycle(2'd3, 8'h00, 8'h9E, '0);
        chk("R5", "zero gap", r_gap, 1);
        chk("R5", "zero setup", r_setup, 1);
        chk("R5", "zero low", r_low, 1);
        chk("R5", "zero high", r_high, 1);

        // R6: no turnaround for the first cycle after reset.
        do_reset();
        run_cycle(2'd3, 8'h00, 8'h47, {4'd2, 4'd2, 4'd2, 4'd2, 3'd6, 5'd1, 2'd1});
        run_cycle(2'd1, 8'h0A, 8'h00, {4'd2, 4'd2, 4'd2, 4'd2, 3'd4, 5'd1, 2'd1});
        chk("R6", "gap after read then address", r_gap, 5);

        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule